// File: doc/BRIEF.md
# Column ADC Ping-Pong Row Buffer

This block sits between the column analog-to-digital converters of an image sensor and the chip's output pins. The columns are split into two halves, a top group and a bottom group. Each half has its own converter group and its own pair of row banks. While the converters of a group fill one bank with the samples of the current row, the other bank streams the previous row out, several 8-bit lanes per clock. Because conversion and readout overlap, a row's readout never holds up the next row's conversion.

Each group writes one 8-bit sample per cycle, addressed by its column index. It closes a row with a row-done strobe. If the read side of that group is idle, the banks swap and the finished row starts streaming on the next cycle, in ascending column order. If the read side is still busy, the strobe is refused. The group then raises a one-cycle overflow flag, and that row is never streamed. Both groups run independently, and each has its own strobe, stream and flag.

Top module: `row_pingpong_buf`

## Requirements
- R1: After reset, and until a group's first row-done strobe, that group's `rd_valid` and `overflow` stay 0, even if samples are written.
- R2: A row-done strobe while the group's stream is idle makes `rd_valid` rise on the next cycle. The row then streams for exactly COLS/(2*LANES) consecutive beats. In beat b, lane i (bits `[i*8 +: 8]` of the group's slice of `rd_data`) carries column b*LANES+i.
- R3: A row-done strobe while the group's `rd_valid` is 1 (the final beat included) raises that group's `overflow` for exactly one cycle, on the next cycle. The current stream continues unchanged, and the refused row is never streamed.
- R4: `rd_last` is 1 only on the final beat of a row. `rd_valid` is 0 on the cycle after that beat unless a new row was accepted.
- R5: Samples written while a row is streaming go to the other bank and do not change the streamed data.
- R6: A sample written in the same cycle as the row-done strobe belongs to the row being closed.
- R7: The top group (index 0: bits `[0 +: ...]` of every per-group port) and the bottom group (index 1) are independent. Strobes, writes and overflows in one group never affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 2 | Sample write enable, one bit per group |
| wr_col | input | 2*CW | Column index within the group, CW = clog2(COLS/2) bits per group |
| wr_data | input | 16 | 8-bit sample per group |
| row_done | input | 2 | Row-complete strobe per group |
| rd_valid | output | 2 | Stream beat valid per group |
| rd_last | output | 2 | Final beat of a row per group |
| rd_data | output | 2*LANES*8 | LANES 8-bit lanes per group, group 0 in the low half |
| overflow | output | 2 | One-cycle flag per group: row refused |

## Verification
The bench builds the block with COLS=16 and LANES=2. Each group is then eight columns deep and streams a row in four beats. Every column of every row is therefore checked in every lane. The small size also lets a strobe be placed on the first beat and on the final beat of a stream within a few cycles. Rows are written in ascending, descending and strided column orders, and the two groups run offset in time. This exposes any lane or bank misrouting, as well as any coupling between the groups.

// File: rtl/row_pingpong_buf.sv
module row_pingpong_buf #(
  parameter int COLS  = 1024,
  parameter int LANES = 4,
  parameter int DW    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                wr_en,
  input  logic [2*$clog2(COLS/2)-1:0] wr_col,
  input  logic [2*DW-1:0]           wr_data,
  input  logic [1:0]                row_done,
  output logic [1:0]                rd_valid,
  output logic [1:0]                rd_last,
  output logic [2*LANES*DW-1:0]     rd_data,
  output logic [1:0]                overflow
);
  localparam int GCOLS = COLS / 2;
  localparam int BEATS = GCOLS / LANES;
  localparam int CW    = $clog2(GCOLS);
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  if (COLS % 2 != 0 || GCOLS % LANES != 0 || BEATS < 2) begin : g_bad_cfg
    $error("row_pingpong_buf: LANES must divide COLS/2 into at least two beats");
  end

  for (genvar g = 0; g < 2; g++) begin : g_grp
    logic [DW-1:0] bank0 [GCOLS];
    logic [DW-1:0] bank1 [GCOLS];
    logic          wsel;
    logic          busy;
    logic [BW-1:0] beat;
    logic          ovf_q;
    logic          in_rng;
    logic          at_end;
    wire  [CW-1:0] col = wr_col[g*CW +: CW];

    if (GCOLS == (1 << CW)) begin : g_pow2
      assign in_rng = 1'b1;
    end else begin : g_npow2
      assign in_rng = col < CW'(GCOLS);
    end

    assign at_end = beat == BW'(BEATS - 1);

    always_ff @(posedge clk) begin
      if (wr_en[g] && in_rng) begin
        if (wsel) bank1[col] <= wr_data[g*DW +: DW];
        else      bank0[col] <= wr_data[g*DW +: DW];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wsel  <= 1'b0;
        busy  <= 1'b0;
        beat  <= '0;
        ovf_q <= 1'b0;
      end else begin
        ovf_q <= 1'b0;
        if (busy) begin
          if (at_end) begin
            busy <= 1'b0;
            beat <= '0;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        if (row_done[g]) begin
          if (busy) begin
            ovf_q <= 1'b1;
          end else begin
            busy <= 1'b1;
            beat <= '0;
            wsel <= ~wsel;
          end
        end
      end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
      wire [CW-1:0] idx = CW'(int'(beat) * LANES + i);
      assign rd_data[(g*LANES + i)*DW +: DW] = wsel ? bank0[idx] : bank1[idx];
    end

    assign rd_valid[g] = busy;
    assign rd_last[g]  = busy && at_end;
    assign overflow[g] = ovf_q;

    a_r4_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last[g] |-> rd_valid[g]);
    a_r4_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last[g] |=> !rd_valid[g]);
    a_r2_stream_unbroken: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid[g] && !rd_last[g] |=> rd_valid[g]);
    a_r2_start_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid[g]) |-> $past(row_done[g]));
    a_r2_idle_done_starts: assert property (@(posedge clk) disable iff (!rst_n)
      row_done[g] && !rd_valid[g] |=> rd_valid[g] && !rd_last[g] && !overflow[g]);
    a_r3_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
      overflow[g] |-> $past(row_done[g] && rd_valid[g]));
    a_r3_busy_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
      row_done[g] && rd_valid[g] |=> overflow[g]);
  end
endmodule

// File: tb/row_pingpong_buf_bench.sv
module row_pingpong_buf_bench;
  localparam int COLS  = 16;
  localparam int LANES = 2;
  localparam int DW    = 8;
  localparam int GCOLS = COLS / 2;
  localparam int BEATS = GCOLS / LANES;
  localparam int CW    = $clog2(GCOLS);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                  rst_n;
  logic [1:0]            wr_en;
  logic [2*CW-1:0]       wr_col;
  logic [2*DW-1:0]       wr_data;
  logic [1:0]            row_done;
  logic [1:0]            rd_valid;
  logic [1:0]            rd_last;
  logic [2*LANES*DW-1:0] rd_data;
  logic [1:0]            overflow;

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;

  row_pingpong_buf #(.COLS(COLS), .LANES(LANES), .DW(DW)) u_row_pingpong_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_col(wr_col), .wr_data(wr_data),
    .row_done(row_done), .rd_valid(rd_valid), .rd_last(rd_last), .rd_data(rd_data),
    .overflow(overflow)
  );

  function automatic logic [DW-1:0] sample(int g, int row, int col);
    return DW'(row * 29 + col * 7 + g * 83 + 3);
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_row(int g, int row, int order, bit close);
    for (int k = 0; k < GCOLS; k++) begin
      int c;
      c = (order == 0) ? k : (order == 1) ? GCOLS - 1 - k : (k * 3) % GCOLS;
      wr_en[g] = 1'b1;
      wr_col[g*CW +: CW] = CW'(c);
      wr_data[g*DW +: DW] = sample(g, row, c);
      row_done[g] = close && (k == GCOLS - 1);
      @(negedge clk);
    end
    wr_en[g] = 1'b0;
    row_done[g] = 1'b0;
  endtask

  task automatic expect_row(int g, int row, bit chk_ovf, string req);
    for (int b = 0; b < BEATS; b++) begin
      logic [LANES*DW-1:0] e;
      for (int i = 0; i < LANES; i++) e[i*DW +: DW] = sample(g, row, b * LANES + i);
      check(req, "lane data", 64'(rd_data[g*LANES*DW +: LANES*DW]), 64'(e));
      check("R2", "valid during row", 64'(rd_valid[g]), 64'd1);
      check("R4", "last flag", 64'(rd_last[g]), 64'(b == BEATS - 1));
      if (chk_ovf) check("R3", "no overflow", 64'(overflow[g]), 64'd0);
      @(negedge clk);
    end
    check("R4", "valid drops after last", 64'(rd_valid[g]), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    wr_en = '0;
    wr_col = '0;
    wr_data = '0;
    row_done = '0;
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", 64'(rd_valid), 64'd0);
    check("R1", "overflow in reset", 64'(overflow), 64'd0);
    rst_n = 1'b1;
    for (int c = 0; c < GCOLS / 2; c++) begin
      wr_en[0] = 1'b1;
      wr_col[0 +: CW] = CW'(c);
      wr_data[0 +: DW] = 8'hA5;
      @(negedge clk);
    end
    wr_en[0] = 1'b0;
    repeat (2) begin
      check("R1", "no valid before first row", 64'(rd_valid), 64'd0);
      check("R1", "no overflow before first row", 64'(overflow), 64'd0);
      @(negedge clk);
    end

    // R6: last column lands in the row_done cycle
    write_row(0, 0, 0, 1'b1);
    expect_row(0, 0, 1'b1, "R6");

    fork
      begin
        write_row(0, 1, 1, 1'b1);
        for (int r = 2; r <= 6; r++) begin
          fork
            expect_row(0, r - 1, 1'b1, "R5");
            write_row(0, r, r % 3, 1'b1);
          join
        end
        expect_row(0, 6, 1'b1, "R2");
      end
      begin
        repeat (3) @(negedge clk);
        write_row(1, 20, 2, 1'b1);
        for (int r = 21; r <= 25; r++) begin
          fork
            expect_row(1, r - 1, 1'b1, "R7");
            write_row(1, r, r % 3, 1'b1);
          join
        end
        expect_row(1, 25, 1'b1, "R7");
      end
    join

    // R3: strobes on the first and on the final beat are refused
    write_row(0, 10, 0, 1'b1);
    fork
      expect_row(0, 10, 1'b0, "R3");
      begin
        row_done[0] = 1'b1;
        @(negedge clk);
        row_done[0] = 1'b0;
        check("R3", "overflow after busy strobe", 64'(overflow[0]), 64'd1);
        check("R7", "other group unaffected", 64'(overflow[1]), 64'd0);
        @(negedge clk);
        check("R3", "overflow one cycle", 64'(overflow[0]), 64'd0);
        @(negedge clk);
        row_done[0] = 1'b1;
        @(negedge clk);
        row_done[0] = 1'b0;
        check("R3", "overflow on final-beat strobe", 64'(overflow[0]), 64'd1);
        check("R3", "refused row not streamed", 64'(rd_valid[0]), 64'd0);
      end
    join
    repeat (2) begin
      @(negedge clk);
      check("R3", "stream stays idle after drop", 64'(rd_valid[0]), 64'd0);
      check("R3", "overflow cleared", 64'(overflow[0]), 64'd0);
    end
    write_row(0, 11, 2, 1'b1);
    expect_row(0, 11, 1'b1, "R3");
    check("R7", "bottom group idle", 64'(rd_valid[1]), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule